// File: doc/BRIEF.md
# Three-Phase Bridge Gate Interlock

This block sits between a motor-control sequencer and the gate drivers of a three-phase full bridge. It receives six active-high switch commands, one high-side and one low-side for each of the phases U, V and W. It returns six gate enables and a supply fault flag. Every command first passes through a synchroniser. A registered interlock stage then passes the commands through unchanged. It forces all six enables low when any single leg is asked to close both of its switches, or when the supply is judged to be too low.

The supply decision comes from one of two sources, selected at elaboration time. One is a sampled supply code compared against a low threshold with a hysteresis band. The other is a single-bit external comparator result, active high meaning undervoltage. Every fault flag transition waits for a programmable number of cycles. The wait is set separately for raising and for clearing. The gates are gated off at once, without waiting for the flag.

Top module: `bridge_interlock`

## Requirements
- R1: With a good supply and no leg conflict, each gate enable equals its own command three clock edges after the command changes (two synchroniser stages and one output register).
- R2: When the high-side and low-side commands of any one phase are both 1, all six gate enables are 0 three edges later, including those of the other two phases.
- R3: Several high-side commands together, several low-side commands together, or a high-side command with a low-side command of a different phase (for example U high with V low) pass through unchanged.
- R4: In code mode, a supply code below UV_LOW makes the detector report undervoltage one edge later, and all gate enables are 0 on the next edge after that, whatever the commands.
- R5: Once undervoltage is reported in code mode, it clears only when the code is at least UV_LOW + UV_HYST. Codes from UV_LOW up to UV_LOW + UV_HYST - 1 keep the current state in either direction.
- R6: A leg conflict never raises the fault flag.
- R7: The fault flag takes the detector's state only after that state has differed from the flag for SET_DLY consecutive cycles when raising, and for CLR_DLY consecutive cycles when clearing.
- R8: During reset and after it, all gate enables are 0 and the fault flag is 1 until the first good-supply decision has been made and its clear delay has run out. The command synchronisers reset to 0.
- R9: In comparator mode, the comparator input (1 = undervoltage) passes through two synchroniser stages and the detector register, so the gates turn off four edges after it rises. The supply code is ignored in this mode, and a code-mode instance ignores the comparator input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 3 | High-side commands, bit 0 = U, bit 1 = V, bit 2 = W |
| lo_cmd | input | 3 | Low-side commands, same bit order as hi_cmd |
| uv_cmp | input | 1 | External comparator result, 1 = undervoltage (comparator mode only) |
| sup_code | input | CODE_W | Sampled supply level (code mode only) |
| hi_gate | output | 3 | High-side gate enables |
| lo_gate | output | 3 | Low-side gate enables |
| uv_fault | output | 1 | Delayed undervoltage fault flag |

## Verification
The gate enables follow a command change on the third edge after it, and follow a supply code change on the second edge. They follow a comparator change on the fourth edge. The flag follows the detector SET_DLY or CLR_DLY edges after the detector itself has changed. The bench drives its inputs on the falling clock edge and records the current edge count. It queues each expected value together with the edge number on which that value becomes due. A falling-edge monitor compares each value only in that exact cycle. Several checks also sample one cycle before a change is due, to show that nothing moves early.

// File: rtl/bil_pkg.sv
package bil_pkg;
   localparam int PHASES = 3;

   typedef struct packed {
      logic [PHASES-1:0] hi;
      logic [PHASES-1:0] lo;
   } gate_set_t;
endpackage

// File: rtl/bil_sync.sv
module bil_sync #(
   parameter int W       = 1,
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("bil_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("bil_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= {W{RST_VAL}};
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/bil_uv_detect.sv
module bil_uv_detect #(
   parameter bit USE_CODE    = 1'b1,
   parameter int CODE_W      = 8,
   parameter int UV_LOW      = 96,
   parameter int UV_HYST     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uv_cmp,
   input  logic [CODE_W-1:0] sup_code,
   output logic              uv_q
);
   if (USE_CODE) begin : g_code
      localparam int UV_HIGH = UV_LOW + UV_HYST;
      localparam logic [CODE_W:0] LO_LIM = UV_LOW[CODE_W:0];
      localparam logic [CODE_W:0] HI_LIM = UV_HIGH[CODE_W:0];

      if (UV_HYST < 1) begin : g_bad_hyst
         $error("bil_uv_detect: UV_HYST must be at least 1");
      end
      if (UV_LOW < 1 || UV_HIGH > (2**CODE_W) - 1) begin : g_bad_range
         $error("bil_uv_detect: thresholds do not fit the code width");
      end

      logic unused_cmp;
      assign unused_cmp = uv_cmp;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    uv_q <= 1'b1;
         else if (uv_q) uv_q <= ({1'b0, sup_code} < HI_LIM);
         else           uv_q <= ({1'b0, sup_code} < LO_LIM);
      end
   end else begin : g_cmp
      logic cmp_s;
      logic [CODE_W-1:0] unused_code;
      assign unused_code = sup_code;

      bil_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cmp_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (uv_cmp),
         .q     (cmp_s)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) uv_q <= 1'b1;
         else        uv_q <= cmp_s;
      end
   end
endmodule

// File: rtl/bil_flag_timer.sv
module bil_flag_timer #(
   parameter int SET_DLY = 250,
   parameter int CLR_DLY = 750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uv_q,
   output logic flag
);
   localparam int MAX_DLY = (SET_DLY > CLR_DLY) ? SET_DLY : CLR_DLY;
   localparam int CW      = $clog2(MAX_DLY + 1);
   localparam logic [CW-1:0] SET_LAST = CW'(SET_DLY - 1);
   localparam logic [CW-1:0] CLR_LAST = CW'(CLR_DLY - 1);

   if (SET_DLY < 1 || CLR_DLY < 1) begin : g_bad_dly
      $error("bil_flag_timer: delays must be at least 1 cycle");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = uv_q ? SET_LAST : CLR_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b1;
         cnt  <= '0;
      end else if (uv_q == flag) begin
         cnt <= '0;
      end else if (cnt == last) begin
         flag <= uv_q;
         cnt  <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/bil_gate_mask.sv
module bil_gate_mask
   import bil_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  gate_set_t cmd,
   input  logic      uv_q,
   output gate_set_t gate
);
   logic [PHASES-1:0] leg_clash;

   for (genvar p = 0; p < PHASES; p++) begin : g_leg
      assign leg_clash[p] = cmd.hi[p] & cmd.lo[p];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    gate <= '0;
      else if (uv_q || (|leg_clash)) gate <= '0;
      else                           gate <= cmd;
   end
endmodule

// File: rtl/bridge_interlock.sv
module bridge_interlock
   import bil_pkg::*;
#(
   parameter bit USE_CODE    = 1'b1,
   parameter int CODE_W      = 8,
   parameter int UV_LOW      = 96,
   parameter int UV_HYST     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SET_DLY     = 250,
   parameter int CLR_DLY     = 750
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        hi_cmd,
   input  logic [2:0]        lo_cmd,
   input  logic              uv_cmp,
   input  logic [CODE_W-1:0] sup_code,
   output logic [2:0]        hi_gate,
   output logic [2:0]        lo_gate,
   output logic              uv_fault
);
   if (PHASES != 3) begin : g_bad_phases
      $error("bridge_interlock: port list assumes three phases");
   end

   gate_set_t         cmd_raw, cmd_s, gate;
   logic [PHASES-1:0] hi_s, lo_s;
   logic              uv_q;

   assign cmd_raw.hi = hi_cmd;
   assign cmd_raw.lo = lo_cmd;

   bil_sync #(.W(2*PHASES), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cmd_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmd_raw),
      .q     (cmd_s)
   );

   assign hi_s = cmd_s.hi;
   assign lo_s = cmd_s.lo;

   bil_uv_detect #(
      .USE_CODE    (USE_CODE),
      .CODE_W      (CODE_W),
      .UV_LOW      (UV_LOW),
      .UV_HYST     (UV_HYST),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_uv (
      .clk      (clk),
      .rst_n    (rst_n),
      .uv_cmp   (uv_cmp),
      .sup_code (sup_code),
      .uv_q     (uv_q)
   );

   bil_gate_mask u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd_s),
      .uv_q  (uv_q),
      .gate  (gate)
   );

   bil_flag_timer #(.SET_DLY(SET_DLY), .CLR_DLY(CLR_DLY)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .uv_q  (uv_q),
      .flag  (uv_fault)
   );

   assign hi_gate = gate.hi;
   assign lo_gate = gate.lo;
endmodule

// File: rtl/bil_checker.sv
module bil_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] hi_s,
   input logic [2:0] lo_s,
   input logic       uv_q,
   input logic [2:0] hi_gate,
   input logic [2:0] lo_gate,
   input logic       uv_fault
);
   // R2
   leg_clash_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((hi_s & lo_s) != 3'b000) |=> (hi_gate == 3'b000 && lo_gate == 3'b000));

   // R4
   uv_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv_q |=> (hi_gate == 3'b000 && lo_gate == 3'b000));

   // R1
   gate_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((hi_gate & ~$past(hi_s)) == 3'b000) && ((lo_gate & ~$past(lo_s)) == 3'b000));

   // R2
   no_leg_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_gate & lo_gate) == 3'b000);

   // R6
   flag_tracks_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(uv_fault) |-> (uv_fault == $past(uv_q)));

   // R8
   uv_gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_q && $past(uv_q)) |-> (hi_gate == 3'b000 && lo_gate == 3'b000));
endmodule

bind bridge_interlock bil_checker u_bil_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .hi_s     (hi_s),
   .lo_s     (lo_s),
   .uv_q     (uv_q),
   .hi_gate  (hi_gate),
   .lo_gate  (lo_gate),
   .uv_fault (uv_fault)
);

// File: tb/sim_bridge_interlock.sv
module sim_bridge_interlock;
   localparam int SET_D = 3;
   localparam int CLR_D = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hi_cmd = 3'b000;
   logic [2:0] lo_cmd = 3'b000;
   logic       uv_cmp = 1'b1;
   logic [7:0] sup_code = 8'd0;
   logic [2:0] hg0, lg0, hg1, lg1;
   logic       f0, f1;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bridge_interlock #(.USE_CODE(1'b1), .UV_LOW(96), .UV_HYST(8),
                      .SET_DLY(SET_D), .CLR_DLY(CLR_D)) u0 (
      .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
      .uv_cmp(uv_cmp), .sup_code(sup_code),
      .hi_gate(hg0), .lo_gate(lg0), .uv_fault(f0));

   bridge_interlock #(.USE_CODE(1'b0), .UV_LOW(96), .UV_HYST(8),
                      .SET_DLY(SET_D), .CLR_DLY(CLR_D)) u1 (
      .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
      .uv_cmp(uv_cmp), .sup_code(sup_code),
      .hi_gate(hg1), .lo_gate(lg1), .uv_fault(f1));

   // sel: 0 = u0 gates {hi,lo}, 1 = u0 flag, 2 = u1 gates, 3 = u1 flag
   typedef struct {
      int         due;
      int         sel;
      logic [5:0] exp;
      string      tag;
   } item_t;
   item_t sbq[$];

   task automatic expect_at(int due, int sel, logic [5:0] exp, string tag);
      item_t it;
      it.due = due; it.sel = sel; it.exp = exp; it.tag = tag;
      sbq.push_back(it);
   endtask

   function automatic logic [5:0] observe(int sel);
      case (sel)
         0:       return {hg0, lg0};
         1:       return {5'b0, f0};
         2:       return {hg1, lg1};
         default: return {5'b0, f1};
      endcase
   endfunction

   task automatic check_now(string tag, logic [5:0] act, logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s cycle %0d actual=%b expected=%b", tag, cyc, act, exp);
      end
   endtask

   // monitor: compares each queued item in the cycle it is due
   always @(negedge clk) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
         if (sbq[i].due == cyc) begin
            check_now(sbq[i].tag, observe(sbq[i].sel), sbq[i].exp);
            sbq.delete(i);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: apply commands and queue expected gates for both instances
   task automatic drive(logic [2:0] hi, logic [2:0] lo,
                        logic [2:0] ehi, logic [2:0] elo, string tag);
      int c;
      hi_cmd = hi;
      lo_cmd = lo;
      c = cyc;
      expect_at(c + 3, 0, {ehi, elo}, tag);
      expect_at(c + 3, 2, {ehi, elo}, tag);
      tick(5);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog cycle %0d actual=running expected=done", cyc);
         finish_run();
      end
   end

   initial begin
      int c;
      logic [5:0] on_pat;
      on_pat = {3'b001, 3'b010};

      // R8: reset state, commands held high are still blocked
      hi_cmd = 3'b001;
      tick(3);
      check_now("R8 u0 gates", {hg0, lg0}, 6'b0);
      check_now("R8 u0 flag", {5'b0, f0}, 6'b1);
      check_now("R8 u1 gates", {hg1, lg1}, 6'b0);
      check_now("R8 u1 flag", {5'b0, f1}, 6'b1);
      hi_cmd = 3'b000;
      sup_code = 8'd200;
      uv_cmp = 1'b0;
      rst_n = 1'b1;
      c = cyc;
      expect_at(c + 7, 1, 6'b1, "R8 u0 flag held");
      expect_at(c + 8, 1, 6'b0, "R7 u0 flag clear");
      expect_at(c + 9, 3, 6'b1, "R9 u1 flag held");
      expect_at(c + 10, 3, 6'b0, "R9 u1 flag clear");
      tick(12);

      drive(3'b001, 3'b000, 3'b001, 3'b000, "R1 U high");
      drive(3'b000, 3'b100, 3'b000, 3'b100, "R1 W low");
      drive(3'b001, 3'b010, 3'b001, 3'b010, "R3 U high V low");
      drive(3'b111, 3'b000, 3'b111, 3'b000, "R3 all high");
      drive(3'b000, 3'b111, 3'b000, 3'b111, "R3 all low");
      c = cyc;
      drive(3'b001, 3'b001, 3'b000, 3'b000, "R2 U leg clash");
      expect_at(cyc, 1, 6'b0, "R6 flag low after clash");
      tick(1);
      drive(3'b011, 3'b100, 3'b011, 3'b100, "R3 U V high W low");
      drive(3'b110, 3'b101, 3'b000, 3'b000, "R2 W clash kills U low");
      expect_at(cyc, 1, 6'b0, "R6 flag low after W clash");
      tick(1);
      drive(3'b001, 3'b010, 3'b001, 3'b010, "R1 recover");

      // R4: code below threshold
      sup_code = 8'd90;
      c = cyc;
      expect_at(c + 1, 0, on_pat, "R4 not early");
      expect_at(c + 2, 0, 6'b0, "R4 gates off");
      expect_at(c + 2, 2, on_pat, "R9 u1 ignores code");
      expect_at(c + 3, 1, 6'b0, "R7 set not early");
      expect_at(c + 4, 1, 6'b1, "R7 set");
      tick(6);

      sup_code = 8'd100;
      c = cyc;
      expect_at(c + 3, 0, 6'b0, "R5 inside band stays off");
      expect_at(c + 5, 1, 6'b1, "R5 flag stays");
      tick(6);

      sup_code = 8'd104;
      c = cyc;
      expect_at(c + 1, 0, 6'b0, "R5 not early");
      expect_at(c + 2, 0, on_pat, "R5 clear at top of band");
      expect_at(c + 7, 1, 6'b1, "R7 clear not early");
      expect_at(c + 8, 1, 6'b0, "R7 clear");
      tick(10);

      sup_code = 8'd100;
      c = cyc;
      expect_at(c + 3, 0, on_pat, "R5 inside band stays on");
      expect_at(c + 5, 1, 6'b0, "R5 flag stays low");
      tick(6);

      sup_code = 8'd96;
      c = cyc;
      expect_at(c + 3, 0, on_pat, "R4 at threshold still good");
      tick(4);

      sup_code = 8'd95;
      c = cyc;
      expect_at(c + 2, 0, 6'b0, "R4 one below threshold");
      tick(3);
      sup_code = 8'd103;
      c = cyc;
      expect_at(c + 3, 0, 6'b0, "R5 one below top stays off");
      tick(4);
      sup_code = 8'd104;
      c = cyc;
      expect_at(c + 2, 0, on_pat, "R5 restore");
      tick(12);

      // R9: comparator mode
      uv_cmp = 1'b1;
      c = cyc;
      expect_at(c + 3, 2, on_pat, "R9 not early");
      expect_at(c + 4, 2, 6'b0, "R9 gates off");
      expect_at(c + 4, 0, on_pat, "R9 u0 ignores comparator");
      expect_at(c + 5, 3, 6'b0, "R9 flag not early");
      expect_at(c + 6, 3, 6'b1, "R9 flag set");
      tick(8);
      uv_cmp = 1'b0;
      c = cyc;
      expect_at(c + 4, 2, on_pat, "R9 gates back");
      expect_at(c + 9, 3, 6'b1, "R9 flag clear not early");
      expect_at(c + 10, 3, 6'b0, "R9 flag clear");
      tick(12);

      while (sbq.size() != 0) tick(1);
      done = 1'b1;
      finish_run();
   end
endmodule